// File: doc/BRIEF.md
# Programmable Cycle-Length Bus Strobe Generator

This block shapes the four data-transfer strobes (I/O request, memory request, read and write) for a single read or write bus cycle of a DMA engine. It runs on a clock at twice the T-cycle rate, so every T-cycle is two clocks: a first half and a second half. This lets a trailing edge fall either at the end of a T-cycle or half a T-cycle earlier.

There are two timing settings, one for the source port and one for the destination port. Each setting gives a cycle length code, a per-strobe early-end mask and a port type (I/O or memory). A start pulse together with a port select launches one cycle. The source port is always read and the destination port is always written. A wait input can stretch the cycle one T-cycle at a time. A one-clock done pulse marks the last clock of the cycle. Address multiplexing and bus arbitration are handled elsewhere.

Top module: `strobe_cycle_gen`

## Requirements
- R1: While reset is low and after it is released, all four strobes and done are low until a start is accepted.
- R2: The length code selects the cycle length in T-cycles: 0 gives 2, 1 gives 3, 2 gives 4, and 3 also gives 4. With no wait, a cycle lasts 2×T clocks, and it begins on the clock after the edge that accepts start.
- R3: A strobe without its early bit stays active from the first clock of the cycle through the last clock of the cycle.
- R4: Early mask bit 0 is I/O request, bit 1 is memory request, bit 2 is read and bit 3 is write. A strobe whose bit is set goes inactive on the last clock of the cycle, which is the second half of the last T-cycle.
- R5: A port with its I/O bit set drives I/O request and not memory request. A port with the bit clear drives memory request. The two are never active together.
- R6: Port select 0 (source) drives read and port select 1 (destination) drives write. The two are never active together.
- R7: Only the selected port's settings affect the cycle. The other port's settings have no effect.
- R8: Wait is sampled on the last clock of the second-to-last T-cycle. Each time it is sampled high, the cycle gains one T-cycle, and wait is sampled again at the end of that added T-cycle.
- R9: Done is high for exactly one clock, the last clock of the cycle. A start during a cycle is ignored. A start on the clock after done is accepted.
- R10: Settings and port select are captured when start is accepted. Changes to them during the cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the T-cycle rate |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a cycle when idle |
| port_sel | input | 1 | 0 selects source (read), 1 selects destination (write) |
| wait_req | input | 1 | Stretch request, active high |
| src_len_code | input | 2 | Source cycle length code |
| src_early | input | 4 | Source early-end mask |
| src_is_io | input | 1 | Source is an I/O port |
| dst_len_code | input | 2 | Destination cycle length code |
| dst_early | input | 4 | Destination early-end mask |
| dst_is_io | input | 1 | Destination is an I/O port |
| iorq_o | output | 1 | I/O request strobe, active high |
| mreq_o | output | 1 | Memory request strobe, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| done_o | output | 1 | One-clock pulse on the final clock of the cycle |

## Verification
The bench builds the block with its default parameters: a 2-bit length code, four strobes and a 3-bit T-cycle index. These values are small enough to sweep every combination of port select, length code, early mask, port type and zero to two wait stretches. For each combination, the bench compares the whole clock-by-clock strobe and done waveform with the one it computes. In every cycle, the other port's settings are driven to complementary values. Mid-cycle, the bench also fires a stray start and flips all settings, so that ignored inputs would show up as a changed waveform.

// File: rtl/strobe_gen_pkg.sv
// Package: shared strobe indices and length decode for the strobe generator.
// Assumes length codes are 2 bits wide; code 3 is folded onto the longest length.
package strobe_gen_pkg;

    localparam int STB_IORQ = 0;
    localparam int STB_MREQ = 1;
    localparam int STB_RD   = 2;
    localparam int STB_WR   = 3;
    localparam int STB_NUM  = 4;

    localparam int LEN_MIN  = 2;
    localparam int LEN_MAX  = 4;

    // Map a length code onto a T-cycle count.
    function automatic int len_of(input logic [1:0] code);
        int n;
        n = LEN_MIN + int'(code);
        if (n > LEN_MAX) n = LEN_MAX;
        return n;
    endfunction

endpackage

// File: rtl/strobe_seq.sv
// Module: strobe_seq
// Walks one bus cycle in half-T-cycle steps. It keeps the T-cycle index and
// the half phase, and inserts wait T-cycles when wait_req is high at the end
// of the second-to-last T-cycle. Assumes last_idx_in >= 1 (at least 2 T-cycles).
module strobe_seq #(
    parameter int TCNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wait_req,
    input  logic [TCNT_W-1:0] last_idx_in,
    output logic              busy_o,
    output logic              final_clk_o
);

    localparam logic [TCNT_W-1:0] ONE = TCNT_W'(1);

    logic              busy_q;
    logic              ph_q;
    logic [TCNT_W-1:0] tidx_q;
    logic [TCNT_W-1:0] last_q;
    logic              at_last;
    logic              at_hold;

    // Position decode within the cycle.
    always_comb begin
        at_last = (tidx_q == last_q);
        at_hold = (tidx_q == (last_q - ONE));
    end

    // Cycle state: launch, half-phase toggle, T-cycle advance and wait hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= 1'b0;
            tidx_q <= '0;
            last_q <= ONE;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                ph_q   <= 1'b0;
                tidx_q <= '0;
                last_q <= last_idx_in;
            end
        end else begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                if (at_last) begin
                    busy_q <= 1'b0;
                end else if (!(at_hold && wait_req)) begin
                    tidx_q <= tidx_q + ONE;
                end
            end
        end
    end

    assign busy_o      = busy_q;
    assign final_clk_o = busy_q && at_last && ph_q;

    // The final clock is always followed by an idle clock.
    assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        final_clk_o |=> !busy_o);

    // An idle start launches at T-cycle 0, first half.
    assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> (busy_q && tidx_q == '0 && !ph_q));

    // The index never passes the final T-cycle.
    assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (tidx_q <= last_q));

    // A sampled wait repeats the second-to-last T-cycle.
    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && ph_q && at_hold && !at_last && wait_req) |=>
            (busy_q && tidx_q == $past(tidx_q) && !ph_q));

endmodule

// File: rtl/strobe_shaper.sv
// Module: strobe_shaper
// Forms each strobe from the busy window, its enable and its early-end bit.
// An early strobe drops on the final clock of the cycle. Assumes final_clk
// is high only while busy.
module strobe_shaper #(
    parameter int NUM_STB = 4
) (
    input  logic               busy,
    input  logic               final_clk,
    input  logic [NUM_STB-1:0] enable,
    input  logic [NUM_STB-1:0] early,
    output logic [NUM_STB-1:0] stb
);

    for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
        // One strobe: active over the busy window, trimmed by half a T-cycle if early.
        always_comb begin
            stb[g] = busy && enable[g] && !(early[g] && final_clk);
        end
    end

endmodule

// File: rtl/strobe_cycle_gen.sv
// Module: strobe_cycle_gen (top)
// Captures the selected port's timing settings on start. It runs the cycle
// sequencer and shapes the four transfer strobes. Source is read, destination
// is written. Assumes clk runs at twice the T-cycle rate.
module strobe_cycle_gen
    import strobe_gen_pkg::*;
#(
    parameter int LEN_CODE_W = 2,
    parameter int NUM_STB    = STB_NUM,
    parameter int TCNT_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  port_sel,
    input  logic                  wait_req,
    input  logic [LEN_CODE_W-1:0] src_len_code,
    input  logic [NUM_STB-1:0]    src_early,
    input  logic                  src_is_io,
    input  logic [LEN_CODE_W-1:0] dst_len_code,
    input  logic [NUM_STB-1:0]    dst_early,
    input  logic                  dst_is_io,
    output logic                  iorq_o,
    output logic                  mreq_o,
    output logic                  rd_o,
    output logic                  wr_o,
    output logic                  done_o
);

    logic                  busy;
    logic                  final_clk;
    logic                  accept;
    logic [LEN_CODE_W-1:0] sel_code;
    logic [TCNT_W-1:0]     last_idx;
    logic [NUM_STB-1:0]    early_q;
    logic [NUM_STB-1:0]    en_q;
    logic [NUM_STB-1:0]    en_next;
    logic [NUM_STB-1:0]    stb;

    // Select the launching port's length and strobe enables.
    always_comb begin
        accept   = start && !busy;
        sel_code = port_sel ? dst_len_code : src_len_code;
        last_idx = TCNT_W'(len_of(2'(sel_code)) - 1);
        en_next  = '0;
        en_next[STB_IORQ] = port_sel ? dst_is_io  : src_is_io;
        en_next[STB_MREQ] = port_sel ? !dst_is_io : !src_is_io;
        en_next[STB_RD]   = !port_sel;
        en_next[STB_WR]   = port_sel;
    end

    // Hold the selected port's strobe settings for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q <= '0;
            en_q    <= '0;
        end else if (accept) begin
            early_q <= port_sel ? dst_early : src_early;
            en_q    <= en_next;
        end
    end

    strobe_seq #(
        .TCNT_W(TCNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wait_req   (wait_req),
        .last_idx_in(last_idx),
        .busy_o     (busy),
        .final_clk_o(final_clk)
    );

    strobe_shaper #(
        .NUM_STB(NUM_STB)
    ) u_shaper (
        .busy     (busy),
        .final_clk(final_clk),
        .enable   (en_q),
        .early    (early_q),
        .stb      (stb)
    );

    assign iorq_o = stb[STB_IORQ];
    assign mreq_o = stb[STB_MREQ];
    assign rd_o   = stb[STB_RD];
    assign wr_o   = stb[STB_WR];
    assign done_o = final_clk;

    // Never both request kinds at once.
    assert_one_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iorq_o, mreq_o}));

    // Never both directions at once.
    assert_one_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_o, wr_o}));

    // A read or write strobe ends only on the final clock or just after it.
    assert_trailing_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_o) |-> (done_o || $past(done_o)));
    assert_trailing_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_o) |-> (done_o || $past(done_o)));

    // Outputs rest low after reset until a start.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !(iorq_o || mreq_o || rd_o || wr_o || done_o));

endmodule

// File: tb/strobe_cycle_gen_bench.sv
// Bench: sweeps port select, length code, early mask, port type and wait count.
// It compares the strobe and done waveform clock by clock with computed values.
module strobe_cycle_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       port_sel = 1'b0;
    logic       wait_req = 1'b0;
    logic [1:0] src_len_code = '0;
    logic [3:0] src_early = '0;
    logic       src_is_io = 1'b0;
    logic [1:0] dst_len_code = '0;
    logic [3:0] dst_early = '0;
    logic       dst_is_io = 1'b0;
    logic       iorq_o, mreq_o, rd_o, wr_o, done_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    strobe_cycle_gen u_strobe_cycle_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .port_sel(port_sel),
        .wait_req(wait_req),
        .src_len_code(src_len_code), .src_early(src_early), .src_is_io(src_is_io),
        .dst_len_code(dst_len_code), .dst_early(dst_early), .dst_is_io(dst_is_io),
        .iorq_o(iorq_o), .mreq_o(mreq_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle from an idle negedge and verify it, ending at the next idle negedge.
    task automatic run_item(input bit sel, input int code, input int early,
                            input bit io, input int w);
        int L, N, first_bad_got, first_bad_exp, done_at, done_cnt;
        bit wave_ok;
        logic [3:0] en, got, exp;
        L = (code == 0) ? 2 : (code == 1) ? 3 : 4;
        N = L + w;
        en[0] = io;  en[1] = !io;  en[2] = !sel;  en[3] = sel;
        // R7: the unselected port gets complementary settings.
        if (sel) begin
            dst_len_code = 2'(code); dst_early = 4'(early); dst_is_io = io;
            src_len_code = 2'(~code); src_early = 4'(~early); src_is_io = !io;
        end else begin
            src_len_code = 2'(code); src_early = 4'(early); src_is_io = io;
            dst_len_code = 2'(~code); dst_early = 4'(~early); dst_is_io = !io;
        end
        port_sel = sel;
        start = 1'b1;
        wave_ok = 1'b1; first_bad_got = 0; first_bad_exp = 0;
        done_at = -1; done_cnt = 0;
        for (int k = 0; k < 2 * N; k++) begin
            @(negedge clk);
            wait_req = (k < 2 * (L - 2) + 2 * w);
            if (k == 0) start = 1'b0;
            if (k == 1) begin
                // R9 stray start, R10 setting changes mid-cycle.
                start = 1'b1;
                port_sel = !sel;
                src_len_code = ~src_len_code; src_early = ~src_early; src_is_io = !src_is_io;
                dst_len_code = ~dst_len_code; dst_early = ~dst_early; dst_is_io = !dst_is_io;
            end
            if (k == 2) start = 1'b0;
            got = {wr_o, rd_o, mreq_o, iorq_o};
            for (int b = 0; b < 4; b++)
                exp[b] = en[b] && ((k < 2 * N - 1) || !early[b]);
            if (got !== exp && wave_ok) begin
                wave_ok = 1'b0;
                first_bad_got = int'(got) | (k << 8);
                first_bad_exp = int'(exp) | (k << 8);
            end
            if (done_o === 1'b1) begin
                done_cnt++;
                done_at = k;
            end
        end
        wait_req = 1'b0;
        // R3 R4 R5 R6 R7 R10: whole strobe waveform, clock index in bits 8+.
        check(wave_ok, "R3 R4 R5 R6 R7 R10 strobe waveform", first_bad_got, first_bad_exp);
        // R2 R8 R9: single done on clock 2N-1.
        check(done_cnt == 1 && done_at == 2 * N - 1, "R2 R8 R9 done position",
              done_at, 2 * N - 1);
        @(negedge clk);
        got = {wr_o, rd_o, mreq_o, iorq_o};
        check(got == 4'b0 && done_o == 1'b0, "R9 idle after cycle", int'({done_o, got}), 0);
    endtask

    initial begin : watchdog
        while (!finished && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        check({iorq_o, mreq_o, rd_o, wr_o, done_o} == 5'b0, "R1 in reset",
              int'({iorq_o, mreq_o, rd_o, wr_o, done_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({iorq_o, mreq_o, rd_o, wr_o, done_o} == 5'b0, "R1 after reset",
              int'({iorq_o, mreq_o, rd_o, wr_o, done_o}), 0);
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 4; c++)
                for (int e = 0; e < 16; e++)
                    for (int i = 0; i < 2; i++)
                        for (int w = 0; w < 3; w++)
                            run_item(s[0], c, e, i[0], w);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule